// File: doc/BRIEF.md
# Windowed Extended Video Memory Mapper

This block lets an 8-bit processor with a 16-bit address bus reach a video memory of up to 16 MB and a separate character generator memory, while giving up less than 1 KB of its own address space. Two 256-byte windows are decoded in the processor map. The low address byte of each access passes straight through to the selected memory. The upper sixteen bits come from a pair of page registers that software writes, with one pair for each window.

To walk through video memory, software writes the two page registers and then indexes through the window. It steps a page register each time the low byte wraps. Accesses that land in a window or on a page register are steered away from system memory.

When the OVERLAY parameter is set, the video window is write-only and lies over ROM. In that mode a write reaches video memory and a read returns ROM contents.

Top module: `xvw_mapper`

## Requirements
- R1: After reset all four page registers read back as 0x00, so a video-window access at offset 0x12 produces video address 0x000012.
- R2: In the default mode, any access with cpu_addr[15:8] = 0xE0 asserts vram_cs, and vram_addr is {register 0xE201, register 0xE200, cpu_addr[7:0]}.
- R3: A write to a page register takes effect at the rising clk edge only when phi2 is high and cpu_rnw is 0 (cpu_rnw = 1 means read). A write with phi2 low leaves the register unchanged.
- R4: A read with cpu_addr[15:8] = 0xE1 asserts fgen_cs, and fgen_addr is {register 0xE203, register 0xE202, cpu_addr[7:0]}. Writing the character-generator registers does not change vram_addr.
- R5: A read of 0xE200 to 0xE203 returns the register contents on cpu_rdata with rdata_oe = 1. rdata_oe is 0 for every other address.
- R6: ram_cs is asserted for addresses 0x0000 to 0x7FFF. rom_cs is asserted for addresses 0xE000 to 0xFFFF that hit neither a window nor a page register. Neither select is asserted for window or register hits, or for 0x8000 to 0xDFFF.
- R7: vram_we is asserted only for a write in the video window while phi2 is high.
- R8: With OVERLAY = 1, a read in the video window asserts rom_cs and not vram_cs, and a write there asserts vram_cs (with vram_we while phi2 is high) and not rom_cs.
- R9: A write in the character-generator window is ignored. fgen_cs, vram_cs, ram_cs and rom_cs all stay low, and no page register changes.
- R10: Only the four exact addresses 0xE200 to 0xE203 are page registers. A write to 0xE204 changes none of them, and a read there selects ROM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that samples register writes |
| rst_n | input | 1 | Active-low reset that clears the page registers |
| cpu_addr | input | 16 | Processor address bus |
| cpu_wdata | input | 8 | Processor write data |
| cpu_rnw | input | 1 | 1 = read, 0 = write |
| phi2 | input | 1 | High during the data phase of the bus cycle |
| vram_addr | output | 24 | Video memory address |
| vram_cs | output | 1 | Video memory select |
| vram_we | output | 1 | Video memory write strobe |
| fgen_addr | output | 24 | Character generator memory address |
| fgen_cs | output | 1 | Character generator memory select |
| ram_cs | output | 1 | System RAM select |
| rom_cs | output | 1 | System ROM select |
| cpu_rdata | output | 8 | Page register readback data |
| rdata_oe | output | 1 | Drive cpu_rdata onto the processor data bus |

## Verification
The hardest condition to reach from the ports is a register write attempt that should be rejected while the address still decodes as a register. Two cases matter: phi2 held low across a clock edge, and the address 0xE204 just past the register block. The stimulus first loads known nonzero values into all four page registers. It then holds each rejected write across a full clock edge and reads every register back. A second instance built with OVERLAY = 1 receives the same bus cycles, so both decodes of the video window are compared in the same cycle.

// File: rtl/xvw_pkg.sv
package xvw_pkg;
  localparam int unsigned CPU_AW   = 16;
  localparam int unsigned DW       = 8;
  localparam int unsigned MEM_AW   = 3 * DW;
  localparam int unsigned NREG     = 4;
  localparam int unsigned RIDX_W   = $clog2(NREG);

  typedef enum logic [2:0] {
    HIT_NONE, HIT_RAM, HIT_ROM, HIT_VWIN, HIT_FWIN, HIT_REG
  } hit_e;

  // Map one processor address to the region it falls in.
  function automatic hit_e classify(input logic [CPU_AW-1:0] a,
                                    input logic [DW-1:0] vpage,
                                    input logic [DW-1:0] fpage,
                                    input logic [DW-1:0] rpage);
    hit_e h;
    if (a[CPU_AW-1 -: DW] == vpage)                    h = HIT_VWIN;
    else if (a[CPU_AW-1 -: DW] == fpage)               h = HIT_FWIN;
    else if (a[CPU_AW-1 -: DW] == rpage &&
             a[DW-1:RIDX_W] == '0)                     h = HIT_REG;
    else if (!a[CPU_AW-1])                             h = HIT_RAM;
    else if (a[CPU_AW-1 -: 3] == 3'b111)               h = HIT_ROM;
    else                                               h = HIT_NONE;
    return h;
  endfunction

  // Join two page bytes and the processor low byte into a wide address.
  function automatic logic [MEM_AW-1:0] compose(input logic [DW-1:0] hi,
                                                input logic [DW-1:0] mid,
                                                input logic [DW-1:0] lo);
    return {hi, mid, lo};
  endfunction
endpackage

// File: rtl/xvw_decode.sv
module xvw_decode
  import xvw_pkg::*;
#(
  parameter logic [DW-1:0] VPAGE   = 8'hE0,
  parameter logic [DW-1:0] FPAGE   = 8'hE1,
  parameter logic [DW-1:0] RPAGE   = 8'hE2,
  parameter bit            OVERLAY = 1'b0
) (
  input  logic [CPU_AW-1:0] addr,
  input  logic              rnw,
  input  logic              phi2,
  output logic              vram_sel,
  output logic              vram_wr,
  output logic              fgen_sel,
  output logic              ram_sel,
  output logic              rom_sel,
  output logic              reg_hit,
  output logic              reg_rd,
  output logic              reg_wr,
  output logic [RIDX_W-1:0] reg_idx
);
  hit_e hit;

  always_comb begin
    hit      = classify(addr, VPAGE, FPAGE, RPAGE);
    vram_sel = 1'b0;
    fgen_sel = 1'b0;
    ram_sel  = 1'b0;
    rom_sel  = 1'b0;
    unique case (hit)
      HIT_VWIN: begin
        if (OVERLAY && rnw) rom_sel  = 1'b1;
        else                vram_sel = 1'b1;
      end
      HIT_FWIN: fgen_sel = rnw;
      HIT_RAM:  ram_sel  = 1'b1;
      HIT_ROM:  rom_sel  = 1'b1;
      default:  ;
    endcase
  end

  assign reg_hit = (hit == HIT_REG);
  assign reg_rd  = reg_hit && rnw;
  assign reg_wr  = reg_hit && !rnw && phi2;
  assign vram_wr = vram_sel && !rnw && phi2;
  assign reg_idx = addr[RIDX_W-1:0];
endmodule

// File: rtl/xvw_pagereg.sv
module xvw_pagereg
  import xvw_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr,
  input  logic [RIDX_W-1:0]       idx,
  input  logic [DW-1:0]           wdata,
  output logic [NREG-1:0][DW-1:0] regs,
  output logic [DW-1:0]           rdata
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              regs[g] <= '0;
      else if (wr && idx == RIDX_W'(g))        regs[g] <= wdata;
    end
  end

  assign rdata = regs[idx];
endmodule

// File: rtl/xvw_mapper.sv
module xvw_mapper
  import xvw_pkg::*;
#(
  parameter logic [7:0] VPAGE   = 8'hE0,
  parameter logic [7:0] FPAGE   = 8'hE1,
  parameter logic [7:0] RPAGE   = 8'hE2,
  parameter bit         OVERLAY = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] cpu_addr,
  input  logic [7:0]  cpu_wdata,
  input  logic        cpu_rnw,
  input  logic        phi2,
  output logic [23:0] vram_addr,
  output logic        vram_cs,
  output logic        vram_we,
  output logic [23:0] fgen_addr,
  output logic        fgen_cs,
  output logic        ram_cs,
  output logic        rom_cs,
  output logic [7:0]  cpu_rdata,
  output logic        rdata_oe
);
  logic                    reg_hit, reg_rd, reg_wr;
  logic [RIDX_W-1:0]       reg_idx;
  logic [NREG-1:0][DW-1:0] page_regs;
  logic [DW-1:0]           reg_q;

  xvw_decode #(.VPAGE(VPAGE), .FPAGE(FPAGE), .RPAGE(RPAGE),
               .OVERLAY(OVERLAY)) u_dec (
    .addr(cpu_addr), .rnw(cpu_rnw), .phi2(phi2),
    .vram_sel(vram_cs), .vram_wr(vram_we), .fgen_sel(fgen_cs),
    .ram_sel(ram_cs), .rom_sel(rom_cs), .reg_hit(reg_hit),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_idx(reg_idx)
  );

  xvw_pagereg u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .idx(reg_idx),
    .wdata(cpu_wdata), .regs(page_regs), .rdata(reg_q)
  );

  assign vram_addr = compose(page_regs[1], page_regs[0], cpu_addr[DW-1:0]);
  assign fgen_addr = compose(page_regs[3], page_regs[2], cpu_addr[DW-1:0]);
  assign cpu_rdata = reg_rd ? reg_q : '0;
  assign rdata_oe  = reg_rd;
endmodule

// File: rtl/xvw_mapper_chk.sv
module xvw_mapper_chk #(
  parameter bit OVERLAY = 1'b0
) (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] cpu_addr,
  input logic        cpu_rnw,
  input logic        phi2,
  input logic [23:0] vram_addr,
  input logic        vram_cs,
  input logic        vram_we,
  input logic        fgen_cs,
  input logic        ram_cs,
  input logic        rom_cs,
  input logic        rdata_oe,
  input logic        reg_hit,
  input logic [31:0] page_regs
);
  // R6
  sys_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vram_cs || fgen_cs || reg_hit) |-> (!ram_cs && !rom_cs));
  // R6
  one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({vram_cs, fgen_cs, ram_cs, rom_cs, rdata_oe}));
  // R7
  we_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vram_we |-> (phi2 && !cpu_rnw && vram_cs));
  // R3
  reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(phi2 && !cpu_rnw) |=> $stable(page_regs));
  // R2
  low_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vram_cs |-> (vram_addr[7:0] == cpu_addr[7:0]));
  // R9
  fgen_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fgen_cs |-> cpu_rnw);
  // R8
  overlay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (OVERLAY && vram_cs) |-> !cpu_rnw);
endmodule

bind xvw_mapper xvw_mapper_chk #(.OVERLAY(OVERLAY)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rnw(cpu_rnw),
  .phi2(phi2), .vram_addr(vram_addr), .vram_cs(vram_cs),
  .vram_we(vram_we), .fgen_cs(fgen_cs), .ram_cs(ram_cs),
  .rom_cs(rom_cs), .rdata_oe(rdata_oe), .reg_hit(reg_hit),
  .page_regs(page_regs)
);

// File: tb/xvw_mapper_test.sv
module xvw_mapper_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = 16'h0000;
  logic [7:0]  cpu_wdata = 8'h00;
  logic        cpu_rnw = 1'b1;
  logic        phi2 = 1'b0;
  logic [23:0] vram_addr, fgen_addr, o_vram_addr, o_fgen_addr;
  logic        vram_cs, vram_we, fgen_cs, ram_cs, rom_cs, rdata_oe;
  logic        o_vram_cs, o_vram_we, o_fgen_cs, o_ram_cs, o_rom_cs, o_oe;
  logic [7:0]  cpu_rdata, o_rdata;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  xvw_mapper uut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rnw(cpu_rnw), .phi2(phi2), .vram_addr(vram_addr), .vram_cs(vram_cs),
    .vram_we(vram_we), .fgen_addr(fgen_addr), .fgen_cs(fgen_cs),
    .ram_cs(ram_cs), .rom_cs(rom_cs), .cpu_rdata(cpu_rdata), .rdata_oe(rdata_oe)
  );

  xvw_mapper #(.OVERLAY(1'b1)) uut_ovl (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rnw(cpu_rnw), .phi2(phi2), .vram_addr(o_vram_addr), .vram_cs(o_vram_cs),
    .vram_we(o_vram_we), .fgen_addr(o_fgen_addr), .fgen_cs(o_fgen_cs),
    .ram_cs(o_ram_cs), .rom_cs(o_rom_cs), .cpu_rdata(o_rdata), .rdata_oe(o_oe)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    cpu_addr = 16'h0000; cpu_rnw = 1'b1; phi2 = 1'b0;
  endtask

  // drive a bus cycle mid-period; outputs are sampled 1 ns later
  task automatic drive(input logic [15:0] a, input logic rnw, input logic p2,
                       input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_rnw = rnw; phi2 = p2; cpu_wdata = d;
    #1;
  endtask

  // write across one rising edge with phi2 high
  task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
    drive(a, 1'b0, 1'b1, d);
    @(posedge clk);
    idle();
  endtask

  task automatic read_reg(input logic [15:0] a, input logic [7:0] exp, input string tag);
    drive(a, 1'b1, 1'b0, 8'h00);
    chk(tag, {23'd0, rdata_oe, cpu_rdata}, {23'd0, 1'b1, exp});
    idle();
  endtask

  task automatic t_reset();
    read_reg(16'hE200, 8'h00, "R1 reg E200");
    read_reg(16'hE201, 8'h00, "R1 reg E201");
    read_reg(16'hE202, 8'h00, "R1 reg E202");
    read_reg(16'hE203, 8'h00, "R1 reg E203");
    drive(16'hE012, 1'b1, 1'b0, 8'h00);
    chk("R1 vram_addr", {8'd0, vram_addr}, 32'h0000_0012);
    idle();
  endtask

  task automatic t_vram_window();
    cpu_write(16'hE200, 8'h5A);
    cpu_write(16'hE201, 8'hC3);
    read_reg(16'hE200, 8'h5A, "R5 readback E200");
    read_reg(16'hE201, 8'hC3, "R5 readback E201");
    drive(16'hE07F, 1'b1, 1'b0, 8'h00);
    chk("R2 vram read", {7'd0, vram_cs, vram_addr}, {7'd0, 1'b1, 24'hC35A7F});
    drive(16'hE0FF, 1'b1, 1'b0, 8'h00);
    chk("R2 vram top", {8'd0, vram_addr}, {8'd0, 24'hC35AFF});
    chk("R5 oe off in window", {31'd0, rdata_oe}, 32'd0);
    idle();
  endtask

  task automatic t_fgen_window();
    cpu_write(16'hE202, 8'h11);
    cpu_write(16'hE203, 8'h22);
    read_reg(16'hE203, 8'h22, "R5 readback E203");
    drive(16'hE130, 1'b1, 1'b0, 8'h00);
    chk("R4 fgen read", {7'd0, fgen_cs, fgen_addr}, {7'd0, 1'b1, 24'h221130});
    chk("R4 vram pages kept", {8'd0, vram_addr}, {8'd0, 24'hC35A30});
    idle();
  endtask

  task automatic t_phi2_gate();
    drive(16'hE200, 1'b0, 1'b0, 8'hFF);
    @(posedge clk);
    idle();
    read_reg(16'hE200, 8'h5A, "R3 no write without phi2");
    drive(16'hE040, 1'b0, 1'b0, 8'h00);
    chk("R7 we low phi2 low", {30'd0, vram_cs, vram_we}, 32'd2);
    drive(16'hE040, 1'b0, 1'b1, 8'h00);
    chk("R7 we high phi2 high", {30'd0, vram_cs, vram_we}, 32'd3);
    drive(16'hE040, 1'b1, 1'b1, 8'h00);
    chk("R7 we low on read", {31'd0, vram_we}, 32'd0);
    idle();
  endtask

  task automatic t_sys_select();
    drive(16'h1234, 1'b1, 1'b0, 8'h00);
    chk("R6 ram", {30'd0, ram_cs, rom_cs}, 32'd2);
    drive(16'hF000, 1'b1, 1'b0, 8'h00);
    chk("R6 rom", {30'd0, ram_cs, rom_cs}, 32'd1);
    drive(16'h9000, 1'b1, 1'b0, 8'h00);
    chk("R6 gap", {30'd0, ram_cs, rom_cs}, 32'd0);
    drive(16'hE010, 1'b1, 1'b0, 8'h00);
    chk("R6 window", {30'd0, ram_cs, rom_cs}, 32'd0);
    drive(16'hE201, 1'b1, 1'b0, 8'h00);
    chk("R6 register", {30'd0, ram_cs, rom_cs}, 32'd0);
    idle();
  endtask

  task automatic t_overlay();
    drive(16'hE005, 1'b1, 1'b0, 8'h00);
    chk("R8 overlay read", {30'd0, o_vram_cs, o_rom_cs}, 32'd1);
    chk("R2 default read", {30'd0, vram_cs, rom_cs}, 32'd2);
    drive(16'hE005, 1'b0, 1'b1, 8'h00);
    chk("R8 overlay write", {29'd0, o_vram_cs, o_vram_we, o_rom_cs}, 32'd6);
    chk("R8 overlay addr", {8'd0, o_vram_addr}, {8'd0, 24'hC35A05});
    idle();
  endtask

  task automatic t_fgen_write_ignored();
    drive(16'hE140, 1'b0, 1'b1, 8'h99);
    chk("R9 fgen write selects", {28'd0, fgen_cs, vram_cs, ram_cs, rom_cs}, 32'd0);
    @(posedge clk);
    idle();
    read_reg(16'hE202, 8'h11, "R9 regs intact E202");
    read_reg(16'hE200, 8'h5A, "R9 regs intact E200");
  endtask

  task automatic t_alias();
    cpu_write(16'hE204, 8'h77);
    read_reg(16'hE200, 8'h5A, "R10 E200 kept");
    read_reg(16'hE201, 8'hC3, "R10 E201 kept");
    read_reg(16'hE202, 8'h11, "R10 E202 kept");
    read_reg(16'hE203, 8'h22, "R10 E203 kept");
    drive(16'hE204, 1'b1, 1'b0, 8'h00);
    chk("R10 E204 is rom", {30'd0, rom_cs, rdata_oe}, 32'd2);
    idle();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_vram_window();
    t_fgen_window();
    t_phi2_gate();
    t_sys_select();
    t_overlay();
    t_fgen_write_ignored();
    t_alias();
    finish_run();
  end

  initial begin
    #800000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule